// File: doc/BRIEF.md
# Synchronous Burst Memory Bus Interface

This block is the clocked slave side of a 32-bit-word memory. A host selects the block with an active-low chip enable, then pulses an active-low address-load strobe for one clock edge. A direction input chosen at that edge makes the access a read or a write. The address is captured at that edge, and the address inputs are not looked at again until the next load. A read returns four words, one at a time, on a registered output. A single read is the same sequence with output enable held low for one clock only.

The first word arrives a programmable number of clocks after the load edge. Each later word follows after a second programmable interval. An active-low advance input holds the sequence in place while it is high. The four addresses either stay within the aligned group of four or count straight upward. A registered drive enable tells the pad logic when to drive the data bus and when to let it float. A write stores the data word presented at the edge after its load edge. The storage is a small internal word array.

Top module: `sync_burst_mem_if`

## Requirements
- R1: After reset, rdata_o is 0 and drive_o is 0. The configuration is first latency 3, step latency 1 and wrap mode on.
- R2: An access starts only at a rising edge where ce_ni is 0 and load_ni is 0. dir_i = 1 selects a read and dir_i = 0 selects a write. A low load_ni while ce_ni is 1 has no effect.
- R3: After the load edge, addr_i is ignored until the next load edge.
- R4: For a read loaded at edge L, word k (k = 0..3) is registered on rdata_o at edge L + X + k*Y while adv_ni stays 0, where X is the first latency and Y is the step latency. After four words rdata_o holds its value.
- R5: adv_ni is sampled only at an edge where a word is due. If it is 1 there, no word is delivered, the address does not step and rdata_o holds. The due word is delivered at the first later edge that has adv_ni = 0.
- R6: In wrap mode, word k comes from {base[ADDR_W-1:2], (base[1:0] + k) mod 4}. The upper bits never change, and the sequence stops after the fourth word.
- R7: In no-wrap mode, word k comes from (base + k) mod 2^ADDR_W, so the address may carry into the upper bits.
- R8: drive_o is 1 in the cycle after an edge that samples oe_ni = 0 and ce_ni = 0. In every other case it is 0. It therefore falls at the first edge after oe_ni rises.
- R9: For a write loaded at edge L, wdata_i is stored at the base address at edge L+1 if ce_ni = 0 and we_ni = 0 there. Otherwise nothing is stored.
- R10: A load edge during a read sequence aborts that sequence. It also cancels a pending write slot. The new access starts from its own address.
- R11: When cfg_we_i = 1 at an edge, cfg_first_i (3-bit X, legal 2..7), cfg_step_i (2-bit Y, legal 1..2) and cfg_wrap_i (1 = wrap) are all taken, but only if both latencies are legal. Otherwise the whole write is ignored. X and wrap are used from the next load. Y is used from the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| load_ni | input | 1 | Address-load strobe, active low |
| dir_i | input | 1 | Access direction: 1 read, 0 write |
| adv_ni | input | 1 | Burst advance, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Word address, sampled at the load edge |
| wdata_i | input | DATA_W | Write data word |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wrap_i | input | 1 | Wrap mode select (1 = wrap) |
| cfg_first_i | input | 3 | First-word latency X |
| cfg_step_i | input | 2 | Per-word latency Y |
| rdata_o | output | DATA_W | Registered read data |
| drive_o | output | 1 | Data bus drive enable (0 = float) |

## Verification
Every word location is first filled with a distinct pattern. Reads from a misaligned base then show whether wrap mode stays inside the aligned group of four or carries upward in no-wrap mode, including a carry out of the top address. Bursts run at the default latencies and at X=5, Y=2, and the advance input is raised at due edges and at non-due edges. This separates a latency count that is off by one from an advance input sampled at the wrong moment. Further patterns toggle the address inputs after the load and abort a read with a new load. They also skip and cancel writes, issue loads with chip enable high, and write an illegal configuration. Each of these shows whether a stale input or an ignored strobe leaks into the data or the timing.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned IDX_W     = $clog2(BURST_LEN);
  localparam int unsigned LAT_W     = 3;
  localparam int unsigned STEP_W    = 2;

  localparam logic [LAT_W-1:0]  FIRST_MIN = 3'd2;
  localparam logic [LAT_W-1:0]  FIRST_MAX = 3'd7;
  localparam logic [LAT_W-1:0]  FIRST_DEF = 3'd3;
  localparam logic [STEP_W-1:0] STEP_MIN  = 2'd1;
  localparam logic [STEP_W-1:0] STEP_MAX  = 2'd2;
  localparam logic [STEP_W-1:0] STEP_DEF  = 2'd1;

  typedef struct packed {
    logic              wrap;
    logic [LAT_W-1:0]  first_lat;
    logic [STEP_W-1:0] step_lat;
  } lat_cfg_t;
endpackage

// File: rtl/sbm_cfg_reg.sv
module sbm_cfg_reg
  import sbm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wrap_i,
  input  logic [LAT_W-1:0]  first_i,
  input  logic [STEP_W-1:0] step_i,
  output lat_cfg_t          cfg_o
);
  logic legal;
  assign legal = (first_i >= FIRST_MIN) && (first_i <= FIRST_MAX) &&
                 (step_i >= STEP_MIN) && (step_i <= STEP_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o.wrap      <= 1'b1;
      cfg_o.first_lat <= FIRST_DEF;
      cfg_o.step_lat  <= STEP_DEF;
    end else if (wr_i && legal) begin
      cfg_o.wrap      <= wrap_i;
      cfg_o.first_lat <= first_i;
      cfg_o.step_lat  <= step_i;
    end
  end

  assert_cfg_guard_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !legal) |=> $stable(cfg_o));
  assert_cfg_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o.first_lat >= FIRST_MIN) && (cfg_o.step_lat >= STEP_MIN) && (cfg_o.step_lat <= STEP_MAX));
endmodule

// File: rtl/sbm_burst_seq.sv
module sbm_burst_seq
  import sbm_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              dir_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  lat_cfg_t          cfg_i,
  output logic              rd_emit_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1);

  logic              busy_q, wr_pend_q, wrap_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LAT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic              due;

  assign due       = busy_q && (cnt_q == '0);
  assign rd_emit_o = due && !adv_ni && !load_i;
  assign wr_en_o   = wr_pend_q && !ce_ni && !we_ni && !load_i;
  assign wr_addr_o = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      wr_pend_q <= 1'b0;
      wrap_q    <= 1'b1;
      idx_q     <= '0;
      cnt_q     <= '0;
      base_q    <= '0;
    end else if (load_i) begin
      base_q    <= addr_i;
      busy_q    <= dir_i;
      wr_pend_q <= !dir_i;
      wrap_q    <= cfg_i.wrap;
      idx_q     <= '0;
      cnt_q     <= cfg_i.first_lat - LAT_W'(1);
    end else begin
      wr_pend_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - LAT_W'(1);
        end else if (!adv_ni) begin
          cnt_q <= LAT_W'(cfg_i.step_lat) - LAT_W'(1);
          if (idx_q == LAST_IDX) busy_q <= 1'b0;
          else                   idx_q  <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  // wrap keeps the upper address bits, no-wrap carries into them
  always_comb begin
    if (wrap_q) rd_addr_o = {base_q[ADDR_W-1:IDX_W], base_q[IDX_W-1:0] + idx_q};
    else        rd_addr_o = base_q + ADDR_W'(idx_q);
  end

  assert_no_early_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !rd_emit_o);
  assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (due && adv_ni && !load_i) |=> (busy_q && $stable(idx_q) && $stable(rd_addr_o)));
  assert_wrap_upper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && wrap_q) |-> (rd_addr_o[ADDR_W-1:IDX_W] == base_q[ADDR_W-1:IDX_W]));
  assert_rw_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_emit_o && wr_en_o));
endmodule

// File: rtl/sbm_word_array.sv
module sbm_word_array #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sync_burst_mem_if.sv
module sync_burst_mem_if
  import sbm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              load_ni,
  input  logic              dir_i,
  input  logic              adv_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cfg_we_i,
  input  logic              cfg_wrap_i,
  input  logic [2:0]        cfg_first_i,
  input  logic [1:0]        cfg_step_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  lat_cfg_t          cfg;
  logic              load;
  logic              rd_emit, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] rdata_q;
  logic              drive_q;

  assign load = !ce_ni && !load_ni;

  sbm_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_we_i),
    .wrap_i  (cfg_wrap_i),
    .first_i (cfg_first_i),
    .step_i  (cfg_step_i),
    .cfg_o   (cfg)
  );

  sbm_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .dir_i     (dir_i),
    .addr_i    (addr_i),
    .adv_ni    (adv_ni),
    .ce_ni     (ce_ni),
    .we_ni     (we_ni),
    .cfg_i     (cfg),
    .rd_emit_o (rd_emit),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr)
  );

  sbm_word_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (wdata_i),
    .raddr_i (rd_addr),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      drive_q <= 1'b0;
    end else begin
      drive_q <= !oe_ni && !ce_ni;
      if (rd_emit) rdata_q <= mem_rdata;
    end
  end

  assign rdata_o = rdata_q;
  assign drive_o = drive_q;

  assert_float_after_oe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_ni) |=> !drive_o);
  assert_float_standby_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> !drive_o);
  assert_ignored_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !rd_emit) |=> $stable(rdata_o));
endmodule

// File: tb/sync_burst_mem_if_test.sv
`timescale 1ns/1ps
module sync_burst_mem_if_test;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, load_n = 1'b1, dir = 1'b1, adv_n = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic cfg_we = 1'b0, cfg_wrap = 1'b1;
  logic [2:0] cfg_first = 3'd3;
  logic [1:0] cfg_step = 2'd1;
  logic [DW-1:0] rdata;
  logic drive;

  always #4 clk = ~clk;

  sync_burst_mem_if #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .load_ni(load_n), .dir_i(dir),
    .adv_ni(adv_n), .oe_ni(oe_n), .we_ni(we_n), .addr_i(addr), .wdata_i(wdata),
    .cfg_we_i(cfg_we), .cfg_wrap_i(cfg_wrap), .cfg_first_i(cfg_first),
    .cfg_step_i(cfg_step), .rdata_o(rdata), .drive_o(drive)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference model
  logic [DW-1:0] mem_m [DEPTH];
  int addr_fifo[$];
  int m_wait, m_x, m_y, m_base;
  bit m_wrap, m_busy, m_wpend;
  logic [DW-1:0] exp_rd;
  bit exp_drive;

  always @(posedge clk) begin
    if (!rst_n) begin
      addr_fifo.delete();
      m_x = 3; m_y = 1; m_wrap = 1; m_busy = 0; m_wpend = 0; m_wait = 0; m_base = 0;
      exp_rd = '0; exp_drive = 0;
    end else begin
      bit ld;
      ld = !ce_n && !load_n;
      if (!ld && m_wpend && !ce_n && !we_n) mem_m[m_base] = wdata;
      m_wpend = 0;
      if (m_busy && !ld) begin
        m_wait = m_wait - 1;
        if (m_wait <= 0 && !adv_n) begin
          exp_rd = mem_m[addr_fifo.pop_front()];
          m_wait = m_y;
          if (addr_fifo.size() == 0) m_busy = 0;
        end
      end
      if (ld) begin
        addr_fifo.delete();
        m_base = int'(addr);
        if (dir) begin
          for (int k = 0; k < 4; k++)
            addr_fifo.push_back(m_wrap ? ((m_base & ~3) | ((m_base + k) & 3))
                                       : ((m_base + k) % DEPTH));
          m_busy = 1; m_wait = m_x;
        end else begin
          m_busy = 0; m_wpend = 1;
        end
      end
      if (cfg_we && cfg_first >= 2 && cfg_first <= 7 && cfg_step >= 1 && cfg_step <= 2) begin
        m_x = int'(cfg_first); m_y = int'(cfg_step); m_wrap = cfg_wrap;
      end
      exp_drive = !oe_n && !ce_n;
    end
  end

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] expv, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rdata, exp_rd, "rdata_o");
      chk({31'd0, drive}, {31'd0, exp_drive}, "drive_o");
    end
  end

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_acc(input int a, input bit d);
    ce_n = 0; load_n = 0; addr = AW'(a); dir = d;
    tk(1);
    load_n = 1; addr = ~AW'(a); dir = ~d;   // scrambled after the load (R3)
  endtask

  task automatic write_word(input int a, input logic [DW-1:0] v, input bit en);
    load_acc(a, 0);
    we_n = !en; wdata = v;
    tk(1);
    we_n = 1; wdata = ~v;
  endtask

  task automatic burst(input int a, input int cycles);
    load_acc(a, 1);
    oe_n = 0;
    tk(cycles);
    oe_n = 1;
    tk(2);
  endtask

  task automatic set_cfg(input bit w, input logic [2:0] x, input logic [1:0] y);
    cfg_we = 1; cfg_wrap = w; cfg_first = x; cfg_step = y;
    tk(1);
    cfg_we = 0;
  endtask

  initial begin
    tk(3);
    rst_n = 1;
    tk(1);
    cur_req = "R1";
    chk(rdata, '0, "reset rdata_o");
    chk({31'd0, drive}, 32'd0, "reset drive_o");

    cur_req = "R9";
    for (int i = 0; i < DEPTH; i++) write_word(i, 32'hC3000000 ^ (32'(i) * 32'h00010203), 1);
    write_word(5, 32'hDEADBEEF, 0);       // we high: skipped
    load_acc(9, 0); ce_n = 1; we_n = 0; wdata = 32'h11111111; tk(1); we_n = 1; ce_n = 0;

    cur_req = "R4";
    load_acc(5, 1); oe_n = 0; tk(1); oe_n = 1; tk(8);  // single read style
    burst(9, 10);

    cur_req = "R6";
    burst(6, 9);
    burst(63, 9);

    cur_req = "R3";
    load_acc(20, 1); oe_n = 0;
    for (int i = 0; i < 8; i++) begin addr = AW'(i * 7); tk(1); end
    oe_n = 1; tk(2);

    cur_req = "R5";
    load_acc(13, 1); oe_n = 0;
    adv_n = 1; tk(1); adv_n = 0; tk(1);   // non-due edges
    adv_n = 1; tk(3); adv_n = 0; tk(1);   // stalled at first word
    adv_n = 1; tk(2); adv_n = 0; tk(6);
    oe_n = 1; tk(2);

    cur_req = "R11";
    set_cfg(0, 3'd5, 2'd2);
    cur_req = "R7";
    burst(6, 16);
    burst(62, 16);
    cur_req = "R11";
    set_cfg(1, 3'd1, 2'd1);               // illegal X: ignored
    set_cfg(1, 3'd4, 2'd3);               // illegal Y: ignored
    burst(30, 16);
    set_cfg(1, 3'd2, 2'd1);
    burst(41, 8);

    cur_req = "R10";
    load_acc(17, 1); oe_n = 0; tk(3);
    load_acc(50, 1); tk(8);
    oe_n = 1; tk(1);
    load_acc(3, 0); load_acc(44, 1); oe_n = 0; tk(7); oe_n = 1; tk(2);
    burst(3, 7);

    cur_req = "R2";
    ce_n = 1; load_n = 0; dir = 1; addr = 6'd12; oe_n = 0; tk(6);
    load_n = 1; oe_n = 1; tk(2);
    ce_n = 0; dir = 0;
    ce_n = 1; load_n = 0; tk(1); load_n = 1; we_n = 0; wdata = 32'h0; tk(1); we_n = 1; ce_n = 0;
    burst(12, 8);

    cur_req = "R8";
    load_acc(33, 1); oe_n = 0; tk(2); ce_n = 1; tk(2); ce_n = 0; tk(2); oe_n = 1; tk(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule